// File: doc/BRIEF.md
# Strap-Selected Target Address Latch

This block supplies the 7-bit target address for a two-wire serial slave. The address comes from a three-state strap pin and is not frozen at reset. A bus front end decodes the strap into low, floating or high. While the block is unlocked, its address output follows that strap immediately. The front end also passes on the serial clock level, a start-condition strobe, its running count of address bits, and a strobe that says the received address bits matched the address this block presents.

The block counts valid transactions. A valid transaction is a start condition followed by seven address bits that match the current address. When the second one arrives, the block freezes the address on the rising serial clock edge that carries the eighth bit of that address byte. After that the strap is ignored until reset. If the strap changes before the freeze, counting begins again from zero, so both counted transactions carry the same address.

Top module: `strap_addr_latch`

## Requirements
- R1: After reset, `addr_locked` is 0 and `slave_addr` is the address decoded from the current strap.
- R2: Strap decoding: 2'b00 (low) gives 7'b1001000, 2'b01 (floating) gives 7'b1001010, 2'b10 (high) gives 7'b1001011, and 2'b11 is treated as floating.
- R3: While unlocked, `slave_addr` follows a strap change in the same cycle, with no register delay.
- R4: One valid transaction alone never sets `addr_locked`.
- R5: `addr_locked` rises on the clock edge that samples a rising `scl` while `bit_cnt` is 7, in the second valid transaction. It stays 0 between that transaction's match strobe and that edge.
- R6: Once locked, `slave_addr` holds the address that was live at the lock edge, whatever the strap does.
- R7: A match strobe counts only when a start was seen in the same address byte and `bit_cnt` equals 7. Any other match strobe has no effect.
- R8: A strap change before lock discards the transactions counted so far.
- R9: The lock is held until reset. Reset releases it, and the address follows the strap again.
- R10: The transaction count saturates at two. If a start arrives before the eighth edge, the pending lock is dropped, and the next valid transaction locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_state | input | 2 | Decoded strap level (encoding in R2) |
| scl | input | 1 | Serial clock level, already synchronized to clk |
| start_det | input | 1 | One-cycle strobe: start condition seen |
| addr_match | input | 1 | One-cycle strobe: received address bits equal `slave_addr` |
| bit_cnt | input | 4 | Number of address bits received in the current byte |
| slave_addr | output | 7 | Address the slave responds to |
| addr_locked | output | 1 | 1 once the address is frozen |

## Verification
The bench checks the one-edge window of the lock. A design that froze on the match strobe, or on the ninth edge instead of the eighth, would show the wrong `addr_locked` value at one of the two samples taken around that edge. It sends match strobes with no preceding start and match strobes at the wrong bit count; a design that counted these would lock one transaction early. It changes the strap between the two transactions; a design that kept the earlier count would lock onto an address seen on the bus only once. It also abandons a pending lock with a repeated start and then changes the strap after the lock; a design that failed either case would lock at the wrong moment or let the frozen address drift.

// File: rtl/sal_pkg.sv
package sal_pkg;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;

  typedef enum logic [STRAP_W-1:0] {
    STRAP_LOW   = 2'b00,
    STRAP_FLOAT = 2'b01,
    STRAP_HIGH  = 2'b10,
    STRAP_RSVD  = 2'b11
  } strap_e;

  // Strap level to 7-bit address; reserved code behaves as floating.
  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [STRAP_W-1:0] s);
    case (s)
      STRAP_LOW:  strap_to_addr = 7'b1001000;
      STRAP_HIGH: strap_to_addr = 7'b1001011;
      default:    strap_to_addr = 7'b1001010;
    endcase
  endfunction
endpackage

// File: rtl/sal_strap_track.sv
module sal_strap_track
  import sal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  output logic               strap_chg
);
  logic [STRAP_W-1:0] strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= STRAP_LOW;
    else        strap_q <= strap;
  end

  assign strap_chg = (strap != strap_q);
endmodule

// File: rtl/sal_occ_count.sv
module sal_occ_count #(
  parameter int BITCNT_W   = 4,
  parameter int ADDR_BITS  = 7,
  parameter int OCC_TARGET = 2,
  localparam int OCC_W     = $clog2(OCC_TARGET + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_det,
  input  logic                addr_match,
  input  logic [BITCNT_W-1:0] bit_cnt,
  input  logic                scl_rise,
  input  logic                strap_chg,
  input  logic                locked,
  output logic [OCC_W-1:0]    occ_cnt,
  output logic                lock_fire
);
  logic armed;
  logic pend;

  logic at_last, hit, byte_end;
  assign at_last  = (bit_cnt == BITCNT_W'(ADDR_BITS));
  assign hit      = armed & addr_match & at_last;
  assign byte_end = scl_rise & at_last;

  assign lock_fire = pend & byte_end & ~locked & ~strap_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      pend    <= 1'b0;
      occ_cnt <= '0;
    end else if (locked) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (strap_chg) begin
      armed   <= 1'b0;
      pend    <= 1'b0;
      occ_cnt <= '0;
    end else if (start_det) begin
      armed <= 1'b1;
      pend  <= 1'b0;
    end else if (byte_end) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else if (hit) begin
      occ_cnt <= (occ_cnt == OCC_W'(OCC_TARGET)) ? occ_cnt : occ_cnt + 1'b1;
      pend    <= (occ_cnt >= OCC_W'(OCC_TARGET - 1));
    end
  end
endmodule

// File: rtl/sal_addr_hold.sv
module sal_addr_hold
  import sal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_fire,
  input  logic [ADDR_W-1:0] live_addr,
  output logic              locked,
  output logic [ADDR_W-1:0] slave_addr
);
  logic [ADDR_W-1:0] held_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      held_addr <= '0;
    end else if (lock_fire) begin
      locked    <= 1'b1;
      held_addr <= live_addr;
    end
  end

  assign slave_addr = locked ? held_addr : live_addr;
endmodule

// File: rtl/strap_addr_latch.sv
module strap_addr_latch
  import sal_pkg::*;
#(
  parameter int BITCNT_W   = 4,
  parameter int ADDR_BITS  = 7,
  parameter int OCC_TARGET = 2,
  localparam int OCC_W     = $clog2(OCC_TARGET + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STRAP_W-1:0]  strap_state,
  input  logic                scl,
  input  logic                start_det,
  input  logic                addr_match,
  input  logic [BITCNT_W-1:0] bit_cnt,
  output logic [ADDR_W-1:0]   slave_addr,
  output logic                addr_locked
);
  // Named internal events, visible to the bound checker.
  logic              scl_q;
  logic              scl_rise;
  logic              strap_chg;
  logic [OCC_W-1:0]  occ_cnt;
  logic              lock_fire;
  logic [ADDR_W-1:0] live_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl;
  end
  assign scl_rise  = scl & ~scl_q;
  assign live_addr = strap_to_addr(strap_state);

  sal_strap_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap_state),
    .strap_chg (strap_chg)
  );

  sal_occ_count #(
    .BITCNT_W   (BITCNT_W),
    .ADDR_BITS  (ADDR_BITS),
    .OCC_TARGET (OCC_TARGET)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .addr_match (addr_match),
    .bit_cnt    (bit_cnt),
    .scl_rise   (scl_rise),
    .strap_chg  (strap_chg),
    .locked     (addr_locked),
    .occ_cnt    (occ_cnt),
    .lock_fire  (lock_fire)
  );

  sal_addr_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_fire  (lock_fire),
    .live_addr  (live_addr),
    .locked     (addr_locked),
    .slave_addr (slave_addr)
  );
endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
  parameter int OCC_TARGET = 2,
  parameter int OCC_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       strap_state,
  input logic [6:0]       slave_addr,
  input logic             addr_locked,
  input logic             scl_rise,
  input logic             strap_chg,
  input logic [OCC_W-1:0] occ_cnt,
  input logic             lock_fire
);
  // Checker's own view of the strap code: the low bits are set by any
  // non-low strap (bit 1) and by the high strap only (bit 0).
  logic [6:0] exp_live;
  assign exp_live = {5'b10010, strap_state != 2'b00, strap_state == 2'b10};

  p_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_locked |-> slave_addr == exp_live);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_locked |=> addr_locked);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_locked && $past(addr_locked) |-> $stable(slave_addr));

  p_lock_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_locked) |-> $past(scl_rise) && $past(occ_cnt) == OCC_W'(OCC_TARGET));

  p_lock_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fire |=> addr_locked);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_chg && !addr_locked |=> occ_cnt == '0);

  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= OCC_W'(OCC_TARGET));
endmodule

bind strap_addr_latch sal_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strap_state (strap_state),
  .slave_addr  (slave_addr),
  .addr_locked (addr_locked),
  .scl_rise    (scl_rise),
  .strap_chg   (strap_chg),
  .occ_cnt     (occ_cnt),
  .lock_fire   (lock_fire)
);

// File: tb/tb_strap_addr_latch.sv
module tb_strap_addr_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_state = 2'b00;
  logic       scl = 1'b1;
  logic       start_det = 1'b0;
  logic       addr_match = 1'b0;
  logic [3:0] bit_cnt = 4'd0;
  logic [6:0] slave_addr;
  logic       addr_locked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_addr_latch dut (
    .clk(clk), .rst_n(rst_n), .strap_state(strap_state), .scl(scl),
    .start_det(start_det), .addr_match(addr_match), .bit_cnt(bit_cnt),
    .slave_addr(slave_addr), .addr_locked(addr_locked)
  );

  // Strap code and expected address, written from R2.
  localparam logic [8:0] DEC_TBL [4] = '{
    {2'b10, 7'h4B}, {2'b00, 7'h48}, {2'b11, 7'h4A}, {2'b01, 7'h4A}
  };

  function automatic logic [6:0] exp_addr(input logic [1:0] s);
    exp_addr = 7'd72 + ((s == 2'b10) ? 7'd3 : (s == 2'b00) ? 7'd0 : 7'd2);
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Start (optional), seven address bits, match strobe at bit count match_at.
  task automatic addr_bits(input bit with_start, input bit with_match, input int match_at);
    @(negedge clk);
    if (with_start) begin
      start_det = 1'b1;
      @(negedge clk); start_det = 1'b0;
    end
    bit_cnt = 4'd0;
    for (int i = 1; i <= 7; i++) begin
      scl = 1'b0;
      @(negedge clk); scl = 1'b1;
      @(negedge clk); scl = 1'b0; bit_cnt = 4'(i);
      if (with_match && i == match_at) begin
        addr_match = 1'b1;
        @(negedge clk); addr_match = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  // Eighth rising edge of the address byte, then byte ends.
  task automatic eighth_edge();
    @(negedge clk); scl = 1'b1;
    @(negedge clk); scl = 1'b0; bit_cnt = 4'd0;
    @(negedge clk);
  endtask

  task automatic good_txn();
    addr_bits(1'b1, 1'b1, 7);
    eighth_edge();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 locked after reset", 7'(addr_locked), 7'd0);
    chk("R1 addr after reset", slave_addr, exp_addr(2'b00));

    // R2/R3: decode table, sampled in the same cycle as the strap change
    foreach (DEC_TBL[k]) begin
      @(negedge clk); strap_state = DEC_TBL[k][8:7];
      #1;
      chk("R2 decode", slave_addr, DEC_TBL[k][6:0]);
      chk("R3 same-cycle follow", slave_addr, exp_addr(DEC_TBL[k][8:7]));
    end

    // R4 / R5 / R6 with floating strap
    @(negedge clk); strap_state = 2'b01;
    @(negedge clk);
    good_txn();
    chk("R4 one transaction no lock", 7'(addr_locked), 7'd0);
    addr_bits(1'b1, 1'b1, 7);
    chk("R5 no lock before eighth edge", 7'(addr_locked), 7'd0);
    @(negedge clk); scl = 1'b1;
    @(posedge clk); #1;
    chk("R5 lock on eighth edge", 7'(addr_locked), 7'd1);
    @(negedge clk); scl = 1'b0; bit_cnt = 4'd0;
    chk("R5 locked addr", slave_addr, 7'h4A);
    strap_state = 2'b10;
    @(negedge clk); @(negedge clk);
    chk("R6 strap ignored after lock", slave_addr, 7'h4A);
    strap_state = 2'b00;
    @(negedge clk);
    chk("R6 strap ignored again", slave_addr, 7'h4A);
    good_txn();
    chk("R9 lock persists", 7'(addr_locked), 7'd1);

    // R9: reset releases lock
    strap_state = 2'b10;
    do_reset();
    @(negedge clk);
    chk("R9 unlocked after reset", 7'(addr_locked), 7'd0);
    chk("R9 follows strap after reset", slave_addr, 7'h4B);

    // R7: match without start, match at wrong count: neither counts
    addr_bits(1'b0, 1'b1, 7); eighth_edge();
    addr_bits(1'b1, 1'b1, 5); eighth_edge();
    good_txn();
    chk("R7 uncounted matches ignored", 7'(addr_locked), 7'd0);
    good_txn();
    chk("R7 second real transaction locks", 7'(addr_locked), 7'd1);
    chk("R7 locked addr", slave_addr, 7'h4B);

    // R8: strap change between transactions restarts count
    strap_state = 2'b00;
    do_reset();
    good_txn();
    @(negedge clk); strap_state = 2'b01;
    @(negedge clk);
    good_txn();
    chk("R8 restart after strap change", 7'(addr_locked), 7'd0);
    good_txn();
    chk("R8 lock after two on new strap", 7'(addr_locked), 7'd1);
    chk("R8 locked to new addr", slave_addr, 7'h4A);

    // R10: repeated start drops pending lock; next valid transaction locks
    strap_state = 2'b10;
    do_reset();
    good_txn();
    addr_bits(1'b1, 1'b1, 7);
    @(negedge clk); bit_cnt = 4'd0;
    good_txn();
    chk("R10 saturated count locks next", 7'(addr_locked), 7'd1);
    chk("R10 locked addr", slave_addr, 7'h4B);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule